// File: doc/BRIEF.md
# Configurable IR Carrier Generator

This block drives a remote-control carrier onto an output pin that is shared with bit 0 of a general output port. A mode strap picks one of two uses for the pin. In level mode the pin is an ordinary push-pull output that mirrors the port latch bit. In carrier mode the latch bit acts as an active-low gate: a 0 lets the carrier run, a 1 stops it and parks the pin low.

The carrier is derived from the instruction clock, which is the system clock divided by four. A divider then splits it by a ratio of base × 2^exp, where the base is 2 or 3 and the exponent is 0 to 3. Every period starts with its high phase. The high phase is half the period, or a third of it, depending on the ratio and a duty strap. Enabling the carrier restarts both the prescaler and the period counter, so the first pulse is never truncated. For example, a 455 kHz system clock with a ratio of 3 gives roughly 37.9 kHz, and a ratio of 2 gives roughly 56.9 kHz.

Top module: `ircg_carrier`

## Requirements
- R1: With `cfg_carrier_mode` = 0 (level mode), `carrier_pin` equals `pc0_latch` in the same cycle, whatever the other configuration inputs are.
- R2: With `cfg_carrier_mode` = 1 and `pc0_latch` = 1, `carrier_pin` is 0 at all times.
- R3: With `cfg_carrier_mode` = 1 and `pc0_latch` = 0, the carrier period lasts 4 × ratio system clock cycles. The ratio is base << `cfg_n_exp`, where base is 2 when `cfg_m_three` = 0 and 3 when `cfg_m_three` = 1.
- R4: When `cfg_m_three` = 0 (ratios 2, 4, 8, 16), the high phase lasts 2 × ratio system cycles, which is half the period, and `cfg_third_duty` has no effect.
- R5: When `cfg_m_three` = 1 and `cfg_n_exp` is 1 to 3 (ratios 6, 12, 24), the high phase is half the period if `cfg_third_duty` = 0 and one third of the period if `cfg_third_duty` = 1.
- R6: When `cfg_m_three` = 1 and `cfg_n_exp` = 0 (ratio 3), the high phase is one third of the period (4 system cycles) regardless of `cfg_third_duty`.
- R7: When the carrier is enabled, `carrier_pin` goes high in the same cycle, and the first high phase has full width, even if an earlier run was stopped partway through a period.
- R8: Reset holds the prescaler and the period counter at the start of a high phase. A carrier that is already enabled when reset is released begins with a full-width high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc0_latch | input | 1 | Port latch bit: the level output in level mode, an active-low enable in carrier mode |
| cfg_carrier_mode | input | 1 | Mode strap: 1 = carrier, 0 = level output |
| cfg_m_three | input | 1 | Ratio base select: 0 = base 2, 1 = base 3 |
| cfg_n_exp | input | NSEL_W | Ratio exponent; the ratio is base << cfg_n_exp |
| cfg_third_duty | input | 1 | Duty select for base-3 ratios above 3: 1 = one third, 0 = half |
| carrier_pin | output | 1 | Pin level |

## Verification
The width properties assume that the mode, base, exponent and duty straps stay constant for as long as the carrier is enabled, because a strap change in the middle of a run would legally produce one odd-length phase. The properties also assume that the latch bit changes no more than once per system cycle. The stimulus only changes straps while the carrier is gated off, either by `pc0_latch` = 1 or by level mode. It changes every input once, shortly after a rising edge, and samples the pin on falling edges. Every phase-width check starts only after the carrier has been enabled, so the low time spent while gated off is never measured as a carrier phase.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
   typedef enum logic {
      MODE_LEVEL   = 1'b0,
      MODE_CARRIER = 1'b1
   } ircg_mode_e;

   // Largest ratio reachable with an exponent field of the given width.
   function automatic int ratio_max(input int nsel_w);
      return 3 << ((1 << nsel_w) - 1);
   endfunction
endpackage

// File: rtl/ircg_prescaler.sv
module ircg_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (!run)         cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/ircg_ratio_decode.sv
module ircg_ratio_decode #(
   parameter int NSEL_W = 2,
   parameter int RW     = 5
) (
   input  logic              m_three,
   input  logic [NSEL_W-1:0] n_exp,
   input  logic              third_duty,
   output logic [RW-1:0]     ratio,
   output logic [RW-1:0]     high_len
);
   logic [RW-1:0] base;
   logic          use_third;

   always_comb begin
      base      = m_three ? RW'(3) : RW'(2);
      ratio     = base << n_exp;
      // Ratio 3 cannot be halved evenly, so it always runs at one third.
      use_third = m_three && ((n_exp == '0) || third_duty);
      // For a base-3 ratio, a third of the period is simply 1 << n.
      high_len  = use_third ? (RW'(1) << n_exp) : (ratio >> 1);
   end
endmodule

// File: rtl/ircg_phase_counter.sv
module ircg_phase_counter #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [RW-1:0] ratio,
   input  logic [RW-1:0] high_len,
   output logic          high
);
   logic [RW-1:0] phase_q;
   logic          wrap;

   assign wrap = (phase_q == ratio - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase_q <= '0;
      else if (!run)  phase_q <= '0;
      else if (tick)  phase_q <= wrap ? '0 : phase_q + 1'b1;
   end

   assign high = (phase_q < high_len);
endmodule

// File: rtl/ircg_carrier.sv
module ircg_carrier #(
   parameter int PRESCALE = 4,
   parameter int NSEL_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc0_latch,
   input  logic              cfg_carrier_mode,
   input  logic              cfg_m_three,
   input  logic [NSEL_W-1:0] cfg_n_exp,
   input  logic              cfg_third_duty,
   output logic              carrier_pin
);
   import ircg_pkg::*;

   localparam int RATIO_MAX = ratio_max(NSEL_W);
   localparam int RW        = $clog2(RATIO_MAX + 1);

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("ircg_carrier: PRESCALE must be at least 1");
      end
      if (NSEL_W < 1 || NSEL_W > 3) begin : g_bad_nsel
         $error("ircg_carrier: NSEL_W must be 1 to 3");
      end
   endgenerate

   ircg_mode_e    mode;
   logic          run;
   logic          tick;
   logic          high;
   logic [RW-1:0] ratio;
   logic [RW-1:0] high_len;

   assign mode = ircg_mode_e'(cfg_carrier_mode);
   assign run  = (mode == MODE_CARRIER) && !pc0_latch;

   ircg_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   ircg_ratio_decode #(.NSEL_W(NSEL_W), .RW(RW)) u_dec (
      .m_three    (cfg_m_three),
      .n_exp      (cfg_n_exp),
      .third_duty (cfg_third_duty),
      .ratio      (ratio),
      .high_len   (high_len)
   );

   ircg_phase_counter #(.RW(RW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .ratio    (ratio),
      .high_len (high_len),
      .high     (high)
   );

   always_comb begin
      if (mode == MODE_CARRIER) carrier_pin = run && high;
      else                      carrier_pin = pc0_latch;
   end
endmodule

// File: rtl/ircg_carrier_chk.sv
module ircg_carrier_chk #(
   parameter int PRESCALE = 4,
   parameter int NSEL_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pc0_latch,
   input logic              cfg_carrier_mode,
   input logic              cfg_m_three,
   input logic [NSEL_W-1:0] cfg_n_exp,
   input logic              cfg_third_duty,
   input logic              carrier_pin
);
   logic        en;
   logic        last_q;
   logic        clean_q;
   logic [15:0] run_q;
   logic        chg;
   int          exp_ratio;
   int          exp_hi;
   int          exp_lo;

   assign en  = cfg_carrier_mode && !pc0_latch;
   assign chg = (carrier_pin != last_q);

   always_comb begin
      exp_ratio = (cfg_m_three ? 3 : 2) * (1 << cfg_n_exp);
      if (cfg_m_three && (cfg_n_exp == '0 || cfg_third_duty))
         exp_hi = exp_ratio / 3;
      else
         exp_hi = exp_ratio / 2;
      exp_lo = exp_ratio - exp_hi;
   end

   // Length of the current run of one pin level, and whether the carrier
   // stayed enabled for the whole run.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= 1'b0;
         run_q   <= '0;
         clean_q <= 1'b0;
      end else begin
         last_q <= carrier_pin;
         if (!en)                 clean_q <= 1'b0;
         else if (chg)            clean_q <= 1'b1;
         if (chg)                 run_q <= 16'd1;
         else if (run_q != '1)    run_q <= run_q + 1'b1;
      end
   end

   p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_carrier_mode |-> (carrier_pin == pc0_latch));

   p_gated_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_carrier_mode && pc0_latch) |-> !carrier_pin);

   p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clean_q && chg && !last_q) |-> (int'(run_q) == exp_lo * PRESCALE));

   p_half_m2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clean_q && chg && last_q && !cfg_m_three)
      |-> (int'(run_q) * 2 == exp_ratio * PRESCALE));

   p_duty_m3_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clean_q && chg && last_q && cfg_m_three && cfg_n_exp != '0)
      |-> (int'(run_q) * (cfg_third_duty ? 3 : 2) == exp_ratio * PRESCALE));

   p_third_r3_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clean_q && chg && last_q && cfg_m_three && cfg_n_exp == '0)
      |-> (int'(run_q) == PRESCALE));

   p_start_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> carrier_pin);
endmodule

bind ircg_carrier ircg_carrier_chk #(.PRESCALE(PRESCALE), .NSEL_W(NSEL_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .pc0_latch        (pc0_latch),
   .cfg_carrier_mode (cfg_carrier_mode),
   .cfg_m_three      (cfg_m_three),
   .cfg_n_exp        (cfg_n_exp),
   .cfg_third_duty   (cfg_third_duty),
   .carrier_pin      (carrier_pin)
);

// File: tb/ircg_carrier_test.sv
module ircg_carrier_test;
   localparam int CLK_PERIOD = 10;
   localparam int PRE = 4;

   typedef struct {
      bit    lvl;
      int    len;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pc0_latch = 1'b1;
   logic       cfg_carrier_mode = 1'b1;
   logic       cfg_m_three = 1'b0;
   logic [1:0] cfg_n_exp = 2'd0;
   logic       cfg_third_duty = 1'b0;
   logic       carrier_pin;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   item_t expq[$];
   bit    mon_on = 0;
   bit    cur_lvl;
   int    run_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   ircg_carrier uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .pc0_latch        (pc0_latch),
      .cfg_carrier_mode (cfg_carrier_mode),
      .cfg_m_three      (cfg_m_three),
      .cfg_n_exp        (cfg_n_exp),
      .cfg_third_duty   (cfg_third_duty),
      .carrier_pin      (carrier_pin)
   );

   task automatic check(input bit got, input bit exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s pin=%0b expected=%0b", req, got, exp);
      end
   endtask

   // Monitor: measure pin run lengths and compare them with the scoreboard.
   always @(negedge clk) begin
      if (mon_on) begin
         if (carrier_pin === cur_lvl) begin
            run_len++;
         end else begin
            total++;
            if (expq.size() == 0) begin
               bad++;
               $display("FAIL R3 unexpected edge after level=%0b len=%0d expected no edge",
                        cur_lvl, run_len);
            end else begin
               item_t it;
               it = expq.pop_front();
               if (it.lvl != cur_lvl || it.len != run_len) begin
                  bad++;
                  $display("FAIL %s run level=%0b len=%0d expected level=%0b len=%0d",
                           it.req, cur_lvl, run_len, it.lvl, it.len);
               end
            end
            cur_lvl = carrier_pin;
            run_len = 1;
         end
      end
   end

   function automatic int hi_cycles(input bit m3, input int n, input bit third);
      int r;
      r = (m3 ? 3 : 2) << n;
      if (m3 && (n == 0 || third)) return (r / 3) * PRE;
      return (r / 2) * PRE;
   endfunction

   // Driver: configure while gated off, queue the expected phases, enable.
   task automatic run_cfg(input bit m3, input int n, input bit third,
                          input int periods, input string req_hi);
      int r;
      int h;
      r = ((m3 ? 3 : 2) << n) * PRE;
      h = hi_cycles(m3, n, third);
      @(posedge clk); #1;
      pc0_latch = 1'b1;
      mon_on = 0;
      cfg_carrier_mode = 1'b1;
      cfg_m_three = m3;
      cfg_n_exp = 2'(n);
      cfg_third_duty = third;
      repeat (3) @(posedge clk);
      #1;
      expq.delete();
      for (int p = 0; p < periods; p++) begin
         expq.push_back('{1'b1, h, req_hi});
         expq.push_back('{1'b0, r - h, "R3"});
      end
      cur_lvl = 1'b1;
      run_len = 0;
      mon_on = 1;
      pc0_latch = 1'b0;
      repeat (periods * r + 2) @(posedge clk);
      #1;
      pc0_latch = 1'b1;
      mon_on = 0;
      total++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL %s phases left=%0d expected=0", req_hi, expq.size());
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R8: reset state, carrier mode gated off
      repeat (3) @(negedge clk);
      check(carrier_pin, 1'b0, "R8 reset gated");
      // R8: enabled at reset release gives a full first pulse
      pc0_latch = 1'b0;
      cfg_m_three = 1'b1;
      cfg_n_exp = 2'd1;
      cfg_third_duty = 1'b1;
      @(posedge clk); #1;
      expq.push_back('{1'b1, 2 * PRE, "R8"});
      expq.push_back('{1'b0, 4 * PRE, "R8"});
      cur_lvl = 1'b1;
      run_len = 0;
      mon_on = 1;
      rst_n = 1'b1;
      repeat (6 * PRE + 2) @(posedge clk);
      #1;
      mon_on = 0;
      pc0_latch = 1'b1;
      total++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL R8 phases left=%0d expected=0", expq.size());
      end

      // R2: gated off for many cycles stays low
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (carrier_pin !== 1'b0) begin
            check(carrier_pin, 1'b0, "R2 gated");
            break;
         end
      end
      check(carrier_pin, 1'b0, "R2 gated");

      // R1: level mode follows the latch bit
      @(posedge clk); #1;
      cfg_carrier_mode = 1'b0;
      pc0_latch = 1'b1;
      @(negedge clk) check(carrier_pin, 1'b1, "R1 level high");
      @(posedge clk); #1;
      pc0_latch = 1'b0;
      cfg_m_three = 1'b0;
      @(negedge clk) check(carrier_pin, 1'b0, "R1 level low");
      repeat (10) @(negedge clk);
      check(carrier_pin, 1'b0, "R1 level held low");
      @(posedge clk); #1;
      pc0_latch = 1'b1;
      @(negedge clk) check(carrier_pin, 1'b1, "R1 level back high");

      // R4: base 2, duty strap ignored
      for (int n = 0; n < 4; n++) run_cfg(1'b0, n, 1'b0, 3, "R4");
      run_cfg(1'b0, 1, 1'b1, 3, "R4");
      run_cfg(1'b0, 3, 1'b1, 2, "R4");
      // R6: ratio 3 is one third either way
      run_cfg(1'b1, 0, 1'b0, 3, "R6");
      run_cfg(1'b1, 0, 1'b1, 3, "R6");
      // R5: base 3, duty selectable
      for (int n = 1; n < 4; n++) begin
         run_cfg(1'b1, n, 1'b0, 3, "R5");
         run_cfg(1'b1, n, 1'b1, 3, "R5");
      end

      // R7: stop partway through a period, then restart with a full pulse
      @(posedge clk); #1;
      cfg_m_three = 1'b1;
      cfg_n_exp = 2'd3;
      cfg_third_duty = 1'b0;
      pc0_latch = 1'b0;
      @(negedge clk) check(carrier_pin, 1'b1, "R7 immediate high");
      repeat (53) @(posedge clk);
      #1;
      pc0_latch = 1'b1;
      @(negedge clk) check(carrier_pin, 1'b0, "R2 stopped");
      run_cfg(1'b1, 3, 1'b0, 2, "R7");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule